// File: doc/BRIEF.md
# APB3 Register Bank with Aliased Enable and Masked Write

This block is a zero-wait-state APB3 slave with a 16-bit address and 32-bit data. It holds six word slots, laid out in 4-byte steps from offset 0. Two of the slots are 32-bit registers that both the bus and on-chip logic can load. One of them lets the hardware load win a same-cycle collision. The other lets the bus write win.

A 4-bit enable vector has a single storage element reached through three addresses. The first sets bits where the write data holds ones. The second clears bits where the write data holds ones. The third only reads the vector back.

A 16-bit register takes a bit-masked write. The upper half of the write word selects which bits change, and the lower half supplies their new values. Any other address reads back a value fixed by a parameter, with no error.

The enable vector and the masked register drive output ports. The hardware load strobes and their values are inputs.

Top module: `apb_alias_regbank`

## Requirements
- R1: After the active-low asynchronous reset, every register reads 0, `en_vec` is 0 and `mask_reg` is 0.
- R2: The address map is fixed as follows. 0x00 is the hardware-priority register and 0x04 is the bus-priority register. 0x08 is enable-set, 0x0C is enable-clear and 0x10 is enable read-only. 0x14 is the masked register, which reads as {16'h0, value}.
- R3: The register at 0x00 loads `hw_val_a` whenever `hw_set_a` is high at a clock edge, even if a bus write to 0x00 commits at the same edge. Otherwise a bus write loads `pwdata`.
- R4: The register at 0x04 loads `pwdata` when a bus write to 0x04 commits, even if `hw_set_b` is high at the same edge. Otherwise `hw_set_b` loads `hw_val_b`.
- R5: A write to 0x08 sets each enable bit whose matching `pwdata[3:0]` bit is 1, and leaves the other bits unchanged.
- R6: A write to 0x0C clears each enable bit whose matching `pwdata[3:0]` bit is 1, and leaves the other bits unchanged.
- R7: A write to 0x10 does not change the enable vector. Reads of 0x08, 0x0C and 0x10 all return {28'h0, en_vec}.
- R8: A write to 0x14 sets the masked register to (old & ~pwdata[31:16]) | (pwdata[15:0] & pwdata[31:16]).
- R9: A read of any other address, including a misaligned one, returns parameter `RSV_VALUE` (default 0). A write to such an address changes no register.
- R10: `pready` is always 1 and `pslverr` is always 0. A write commits only at an edge where `psel`, `penable` and `pwrite` are all high, so a setup phase alone writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Clock |
| presetn | input | 1 | Asynchronous reset, active low |
| paddr | input | 16 | Byte address |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase |
| pwrite | input | 1 | 1 = write, 0 = read |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data |
| pready | output | 1 | Always ready |
| pslverr | output | 1 | Always low |
| hw_set_a | input | 1 | Hardware load strobe, register 0x00 |
| hw_val_a | input | 32 | Hardware load value, register 0x00 |
| hw_set_b | input | 1 | Hardware load strobe, register 0x04 |
| hw_val_b | input | 32 | Hardware load value, register 0x04 |
| en_vec | output | 4 | Enable vector |
| mask_reg | output | 16 | Masked-write register |

## Verification
The properties assume a single well-formed master. At most one transfer is in flight, `paddr` and `pwdata` hold steady through the access phase, and `penable` is raised only after a setup phase. The bench drives every transfer through one write task and one read task that follow that two-phase order. It changes the hardware strobes only at falling edges. It checks write-collision priority by raising a strobe exactly during the access phase of a write to the same register.

// File: rtl/apb_alias_regbank.sv
module apb_alias_regbank #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int EN_W = 4,
  parameter logic [DATA_W-1:0] RSV_VALUE = '0
) (
  input  logic              pclk,
  input  logic              presetn,
  input  logic [ADDR_W-1:0] paddr,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [DATA_W-1:0] pwdata,
  output logic [DATA_W-1:0] prdata,
  output logic              pready,
  output logic              pslverr,
  input  logic              hw_set_a,
  input  logic [DATA_W-1:0] hw_val_a,
  input  logic              hw_set_b,
  input  logic [DATA_W-1:0] hw_val_b,
  output logic [EN_W-1:0]   en_vec,
  output logic [DATA_W/2-1:0] mask_reg
);
  localparam int HALF = DATA_W / 2;
  localparam int NSLOT = 6;

  logic [DATA_W-1:0] reg_a, reg_b;
  logic [NSLOT-1:0]  hit;
  logic              wr;

  assign wr      = psel & penable & pwrite;
  assign pready  = 1'b1;
  assign pslverr = 1'b0;

  for (genvar k = 0; k < NSLOT; k++) begin : g_dec
    assign hit[k] = (paddr == ADDR_W'(4 * k));
  end

  // R3: hardware load dominates
  always_ff @(posedge pclk or negedge presetn)
    if (!presetn)                reg_a <= '0;
    else if (hw_set_a)           reg_a <= hw_val_a;
    else if (wr && hit[0])       reg_a <= pwdata;

  // R4: bus write dominates
  always_ff @(posedge pclk or negedge presetn)
    if (!presetn)                reg_b <= '0;
    else if (wr && hit[1])       reg_b <= pwdata;
    else if (hw_set_b)           reg_b <= hw_val_b;

  // R5, R6, R7: one enable store behind three addresses
  always_ff @(posedge pclk or negedge presetn)
    if (!presetn)                en_vec <= '0;
    else if (wr && hit[2])       en_vec <= en_vec | pwdata[EN_W-1:0];
    else if (wr && hit[3])       en_vec <= en_vec & ~pwdata[EN_W-1:0];

  // R8: upper half selects, lower half supplies
  always_ff @(posedge pclk or negedge presetn)
    if (!presetn)                mask_reg <= '0;
    else if (wr && hit[5])
      mask_reg <= (mask_reg & ~pwdata[DATA_W-1:HALF]) | (pwdata[HALF-1:0] & pwdata[DATA_W-1:HALF]);

  // R2, R9: read mux
  always_comb begin
    prdata = RSV_VALUE;
    if (hit[0]) prdata = reg_a;
    if (hit[1]) prdata = reg_b;
    if (hit[2] || hit[3] || hit[4]) prdata = {{(DATA_W-EN_W){1'b0}}, en_vec};
    if (hit[5]) prdata = {{HALF{1'b0}}, mask_reg};
  end
endmodule

module apb_alias_regbank_chk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int EN_W = 4
) (
  input logic              pclk,
  input logic              presetn,
  input logic [ADDR_W-1:0] paddr,
  input logic              psel,
  input logic              penable,
  input logic              pwrite,
  input logic [DATA_W-1:0] pwdata,
  input logic              pready,
  input logic              pslverr,
  input logic              hw_set_a,
  input logic [DATA_W-1:0] hw_val_a,
  input logic              hw_set_b,
  input logic [DATA_W-1:0] hw_val_b,
  input logic [DATA_W-1:0] reg_a,
  input logic [DATA_W-1:0] reg_b,
  input logic [EN_W-1:0]   en_vec,
  input logic [DATA_W/2-1:0] mask_reg
);
  localparam int HALF = DATA_W / 2;
  logic cw;
  assign cw = psel && penable && pwrite;

  a_r10_ready_no_err: assert property (@(posedge pclk) disable iff (!presetn)
    pready && !pslverr);
  a_r3_hw_wins: assert property (@(posedge pclk) disable iff (!presetn)
    hw_set_a |=> reg_a == $past(hw_val_a));
  a_r4_sw_wins: assert property (@(posedge pclk) disable iff (!presetn)
    (cw && paddr == ADDR_W'(4)) |=> reg_b == $past(pwdata));
  a_r4_hw_alone: assert property (@(posedge pclk) disable iff (!presetn)
    (hw_set_b && !(cw && paddr == ADDR_W'(4))) |=> reg_b == $past(hw_val_b));
  a_r5_set_bits: assert property (@(posedge pclk) disable iff (!presetn)
    (cw && paddr == ADDR_W'(8)) |=> en_vec == ($past(en_vec) | $past(pwdata[EN_W-1:0])));
  a_r6_clr_bits: assert property (@(posedge pclk) disable iff (!presetn)
    (cw && paddr == ADDR_W'(12)) |=> en_vec == ($past(en_vec) & ~$past(pwdata[EN_W-1:0])));
  a_r7_ro_alias: assert property (@(posedge pclk) disable iff (!presetn)
    (cw && paddr == ADDR_W'(16)) |=> $stable(en_vec));
  a_r8_masked: assert property (@(posedge pclk) disable iff (!presetn)
    (cw && paddr == ADDR_W'(20)) |=> mask_reg ==
      (($past(mask_reg) & ~$past(pwdata[DATA_W-1:HALF])) |
       ($past(pwdata[HALF-1:0]) & $past(pwdata[DATA_W-1:HALF]))));
  a_r10_no_commit: assert property (@(posedge pclk) disable iff (!presetn)
    !cw |=> $stable(en_vec) && $stable(mask_reg));
endmodule

bind apb_alias_regbank apb_alias_regbank_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .EN_W(EN_W)) u_chk (
  .pclk(pclk), .presetn(presetn), .paddr(paddr), .psel(psel), .penable(penable),
  .pwrite(pwrite), .pwdata(pwdata), .pready(pready), .pslverr(pslverr),
  .hw_set_a(hw_set_a), .hw_val_a(hw_val_a), .hw_set_b(hw_set_b), .hw_val_b(hw_val_b),
  .reg_a(reg_a), .reg_b(reg_b), .en_vec(en_vec), .mask_reg(mask_reg)
);

// File: tb/apb_alias_regbank_tb_top.sv
module apb_alias_regbank_tb_top;
  localparam int CLK_P = 10;
  localparam logic [31:0] RSV = 32'h0000EF00;

  logic clk = 0, rstn = 0;
  logic [15:0] paddr = '0;
  logic psel = 0, penable = 0, pwrite = 0;
  logic [31:0] pwdata = '0, prdata;
  logic pready, pslverr;
  logic hsa = 0, hsb = 0;
  logic [31:0] hva = '0, hvb = '0;
  logic [3:0] en_vec;
  logic [15:0] mask_reg;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  apb_alias_regbank #(.RSV_VALUE(RSV)) dut_i (
    .pclk(clk), .presetn(rstn), .paddr(paddr), .psel(psel), .penable(penable),
    .pwrite(pwrite), .pwdata(pwdata), .prdata(prdata), .pready(pready), .pslverr(pslverr),
    .hw_set_a(hsa), .hw_val_a(hva), .hw_set_b(hsb), .hw_val_b(hvb),
    .en_vec(en_vec), .mask_reg(mask_reg));

  typedef struct packed {
    logic        wr;
    logic [15:0] a;
    logic [31:0] d;
    logic [31:0] e;
    logic [3:0]  r;
  } vec_t;

  localparam int NV = 22;
  localparam vec_t TBL [0:NV-1] = '{
    '{1'b1, 16'h0000, 32'h12345678, 32'h0,        4'd2}, // R2
    '{1'b0, 16'h0000, 32'h0,        32'h12345678, 4'd2},
    '{1'b1, 16'h0004, 32'hCAFEF00D, 32'h0,        4'd2},
    '{1'b0, 16'h0004, 32'h0,        32'hCAFEF00D, 4'd2},
    '{1'b1, 16'h0008, 32'h00000005, 32'h0,        4'd5}, // R5
    '{1'b0, 16'h0010, 32'h0,        32'h00000005, 4'd5},
    '{1'b1, 16'h0008, 32'hFFFFFFF2, 32'h0,        4'd5},
    '{1'b0, 16'h0008, 32'h0,        32'h00000007, 4'd5},
    '{1'b1, 16'h000C, 32'h00000004, 32'h0,        4'd6}, // R6
    '{1'b0, 16'h000C, 32'h0,        32'h00000003, 4'd6},
    '{1'b1, 16'h0010, 32'h0000000F, 32'h0,        4'd7}, // R7
    '{1'b0, 16'h0010, 32'h0,        32'h00000003, 4'd7},
    '{1'b1, 16'h0014, 32'hFFFF1234, 32'h0,        4'd8}, // R8
    '{1'b0, 16'h0014, 32'h0,        32'h00001234, 4'd8},
    '{1'b1, 16'h0014, 32'h00F0FFFF, 32'h0,        4'd8},
    '{1'b0, 16'h0014, 32'h0,        32'h000012F4, 4'd8},
    '{1'b1, 16'h0014, 32'h00000000, 32'h0,        4'd8},
    '{1'b0, 16'h0014, 32'h0,        32'h000012F4, 4'd8},
    '{1'b1, 16'h0018, 32'hFFFFFFFF, 32'h0,        4'd9}, // R9
    '{1'b0, 16'h0018, 32'h0,        RSV,          4'd9},
    '{1'b0, 16'h03FC, 32'h0,        RSV,          4'd9},
    '{1'b0, 16'h0002, 32'h0,        RSV,          4'd9}
  };

  function automatic string rq(input int r);
    case (r)
      1: return "R1";  2: return "R2";  3: return "R3";  4: return "R4";
      5: return "R5";  6: return "R6";  7: return "R7";  8: return "R8";
      9: return "R9";  default: return "R10";
    endcase
  endfunction

  task automatic check(input string r, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [31:0] d);
    @(negedge clk); psel = 1; pwrite = 1; penable = 0; paddr = a; pwdata = d;
    @(negedge clk); penable = 1;
    @(negedge clk); psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [31:0] d, output logic err);
    @(negedge clk); psel = 1; pwrite = 0; penable = 0; paddr = a;
    @(negedge clk); penable = 1;
    #1 d = prdata; err = pslverr | ~pready;
    @(negedge clk); psel = 0; penable = 0;
  endtask

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      n_fail++;
      $display("FAIL R10 actual=watchdog expected=completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic e;
    repeat (3) @(negedge clk);
    rstn = 1;
    // R1: reset state
    check("R1", {28'h0, en_vec}, 32'h0);
    check("R1", {16'h0, mask_reg}, 32'h0);
    for (int a = 0; a < 24; a += 4) begin
      rd(16'(a), v, e);
      check("R1", v, 32'h0);
    end
    // table walk
    for (int i = 0; i < NV; i++) begin
      if (TBL[i].wr) wr(TBL[i].a, TBL[i].d);
      else begin
        rd(TBL[i].a, v, e);
        check(rq(int'(TBL[i].r)), v, TBL[i].e);
        check("R10", {31'h0, e}, 32'h0);
      end
    end
    check("R7", {28'h0, en_vec}, 32'h3);
    check("R8", {16'h0, mask_reg}, 32'h12F4);
    // R9: reserved write left all registers alone
    rd(16'h0000, v, e); check("R9", v, 32'h12345678);
    rd(16'h0004, v, e); check("R9", v, 32'hCAFEF00D);
    // R3: collision, hardware wins
    @(negedge clk); psel = 1; pwrite = 1; paddr = 16'h0000; pwdata = 32'h11111111;
    @(negedge clk); penable = 1; hsa = 1; hva = 32'hA5A5A5A5;
    @(negedge clk); psel = 0; penable = 0; pwrite = 0; hsa = 0;
    rd(16'h0000, v, e); check("R3", v, 32'hA5A5A5A5);
    // R4: collision, bus wins
    @(negedge clk); psel = 1; pwrite = 1; paddr = 16'h0004; pwdata = 32'h22222222;
    @(negedge clk); penable = 1; hsb = 1; hvb = 32'h5A5A5A5A;
    @(negedge clk); psel = 0; penable = 0; pwrite = 0; hsb = 0;
    rd(16'h0004, v, e); check("R4", v, 32'h22222222);
    // R3, R4: hardware load alone
    @(negedge clk); hsa = 1; hva = 32'h0BADBEEF; hsb = 1; hvb = 32'hDEADC0DE;
    @(negedge clk); hsa = 0; hsb = 0;
    rd(16'h0000, v, e); check("R3", v, 32'h0BADBEEF);
    rd(16'h0004, v, e); check("R4", v, 32'hDEADC0DE);
    // R10: setup phase only, no commit
    @(negedge clk); psel = 1; pwrite = 1; penable = 0; paddr = 16'h0008; pwdata = 32'hF;
    @(negedge clk); psel = 0; pwrite = 0;
    @(negedge clk);
    check("R10", {28'h0, en_vec}, 32'h3);
    // R6: clear everything
    wr(16'h000C, 32'hF);
    check("R6", {28'h0, en_vec}, 32'h0);
    // R1: asynchronous reset mid-run
    @(negedge clk); rstn = 0; #1;
    check("R1", {28'h0, en_vec} | {16'h0, mask_reg}, 32'h0);
    @(negedge clk); rstn = 1;
    rd(16'h0004, v, e); check("R1", v, 32'h0);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule